// File: doc/BRIEF.md
# Main System Clock Source Controller

This block chooses which of two high-speed sources drives the main clock of a microcontroller core and its peripherals. One source is the high-speed system clock, from a crystal oscillator or an external clock input. The other is an on-chip high-speed oscillator whose frequency is set by a code. Software reaches three small registers through a simple write/read port: a stop register with one stop bit per source, a select register with the source-select bit and a live status bit, and a frequency register for the on-chip oscillator.

The oscillators themselves are outside the block. The block drives an enable to each oscillator and receives a clock and a clock-valid flag back from each. A STOP input, held high while the core executes its STOP instruction, removes both enables at once. The main clock output is built from the two source clocks by a handshaking gate. The gate switches off the old source on that source's own falling edge. It switches on the new source only after a two-flop synchroniser in the new source's domain has seen that the old source is off. The output therefore never carries a shortened pulse.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset the select bit is 0, the high-speed system clock stop bit is 1, the on-chip stop bit is 0 and the frequency register equals `cfg_freq`. The main clock then runs from the on-chip oscillator once `ih_valid` is high.
- R2: Frequency codes 0..9 mean 32, 24, 16, 12, 8, 6, 4, 3, 2 and 1 MHz. `cfg_mode` 0 allows all ten codes, 1 allows codes 1..9, and 2 or 3 allows codes 6..9. A write at address 2 with a code above 9, or with a code not allowed in the current mode, leaves the register unchanged. The register drives `ih_freq`.
- R3: Address 0 holds the high-speed system clock stop bit in bit 7 and the on-chip stop bit in bit 0. Other bits read 0. `hs_osc_en` is high exactly when bit 7 is clear and `stop_req` is low. `ih_osc_en` is high exactly when bit 0 is clear and `stop_req` is low.
- R4: While `stop_req` is high, both oscillator enables are low. When `stop_req` falls, only the sources whose stop bit is clear are enabled again.
- R5: Bit 4 at address 1 selects the main source: 0 is the on-chip oscillator and 1 is the high-speed system clock. A write that selects a source whose stop bit is set is ignored.
- R6: A write that sets the stop bit of the selected source, or of the source currently driving the main clock, leaves that bit unchanged.
- R7: The switch between sources is glitch-free. The two source gates are never on together, and every high pulse of `main_clk` is a full high phase of one source. Bit 5 at address 1 and the `src_hs` output report 1 while the high-speed system clock drives `main_clk`.
- R8: `main_clk` stays low while the selected source's valid input is low, or while `stop_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_freq | input | 4 | Configuration-byte frequency code, loaded at reset |
| cfg_mode | input | 2 | Operating mode: 0 high-speed, 1 low-speed, 2/3 low-voltage |
| stop_req | input | 1 | STOP instruction in progress |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| hs_clk | input | 1 | High-speed system clock (crystal or external) |
| hs_valid | input | 1 | High-speed system clock is stable |
| ih_clk | input | 1 | On-chip oscillator clock |
| ih_valid | input | 1 | On-chip oscillator clock is stable |
| hs_osc_en | output | 1 | Enable to crystal oscillator / external input |
| ih_osc_en | output | 1 | Enable to on-chip oscillator |
| ih_freq | output | 4 | Frequency code for on-chip oscillator |
| main_clk | output | 1 | Glitch-free main system clock |
| src_hs | output | 1 | High-speed system clock is driving main_clk |

## Verification
A wrong stop or select bit shows up on the oscillator enables in the cycle after the write, and through a read at once. A wrong frequency value reaches `ih_freq` in the same cycle. A fault in the switching gates shows on `main_clk` within a few source periods, as a high pulse shorter than a source half period or as an edge rate that does not match the selected source. A wrong status bit shows on `src_hs` within about two register clocks of the gate changing. The bench measures every high pulse of `main_clk` and counts its edges over fixed windows to catch these cases.

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cfg_freq,
  input  logic [1:0] cfg_mode,
  input  logic       stop_req,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       hs_clk,
  input  logic       hs_valid,
  input  logic       ih_clk,
  input  logic       ih_valid,
  output logic       hs_osc_en,
  output logic       ih_osc_en,
  output logic [3:0] ih_freq,
  output logic       main_clk,
  output logic       src_hs
);
  localparam logic [3:0] MAX_CODE = 4'd9;

  logic       hs_stop, ih_stop, sel_hs;
  logic [3:0] freq;
  logic [1:0] hs_s, ih_s, hs_act_s, ih_act_s;
  logic       hs_on, ih_on;
  logic       hs_act, ih_act;

  function automatic logic code_ok(input logic [3:0] c, input logic [1:0] m);
    if (c > MAX_CODE) return 1'b0;
    case (m)
      2'd0:    return 1'b1;
      2'd1:    return c >= 4'd1;
      default: return c >= 4'd6;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_stop <= 1'b1;
      ih_stop <= 1'b0;
      sel_hs  <= 1'b0;
      freq    <= cfg_freq;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          if (!(wr_data[7] && (sel_hs || hs_act))) hs_stop <= wr_data[7];
          if (!(wr_data[0] && (!sel_hs || ih_act))) ih_stop <= wr_data[0];
        end
        2'd1: if (!(wr_data[4] ? hs_stop : ih_stop)) sel_hs <= wr_data[4];
        2'd2: if (code_ok(wr_data[3:0], cfg_mode)) freq <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  assign hs_osc_en = !hs_stop && !stop_req;
  assign ih_osc_en = !ih_stop && !stop_req;
  assign ih_freq   = freq;

  always_ff @(posedge ih_clk or negedge rst_n)
    if (!rst_n) ih_s <= 2'b00;
    else        ih_s <= {ih_s[0], !sel_hs && ih_valid && ih_osc_en && !hs_on};

  always_ff @(negedge ih_clk or negedge rst_n)
    if (!rst_n) ih_on <= 1'b0;
    else        ih_on <= ih_s[1];

  always_ff @(posedge hs_clk or negedge rst_n)
    if (!rst_n) hs_s <= 2'b00;
    else        hs_s <= {hs_s[0], sel_hs && hs_valid && hs_osc_en && !ih_on};

  always_ff @(negedge hs_clk or negedge rst_n)
    if (!rst_n) hs_on <= 1'b0;
    else        hs_on <= hs_s[1];

  assign main_clk = (ih_clk && ih_on) || (hs_clk && hs_on);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_act_s <= 2'b00;
      ih_act_s <= 2'b00;
    end else begin
      hs_act_s <= {hs_act_s[0], hs_on};
      ih_act_s <= {ih_act_s[0], ih_on};
    end

  assign hs_act = hs_act_s[1];
  assign ih_act = ih_act_s[1];
  assign src_hs = hs_act;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {hs_stop, 6'b0, ih_stop};
      2'd1:    rd_data = {2'b0, hs_act, sel_hs, 4'b0};
      2'd2:    rd_data = {4'b0, freq};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_req,
  input logic       hs_osc_en,
  input logic       ih_osc_en,
  input logic       sel_hs,
  input logic       hs_stop,
  input logic       ih_stop,
  input logic       hs_on,
  input logic       ih_on,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [3:0] freq
);
  assert_stop_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (!hs_osc_en && !ih_osc_en));

  assert_sel_not_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hs |-> !hs_stop);

  assert_ih_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hs |-> !ih_stop);

  assert_one_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ih_on));

  assert_freq_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq) |-> $past(wr_en && wr_addr == 2'd2));
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
  .hs_osc_en(hs_osc_en), .ih_osc_en(ih_osc_en),
  .sel_hs(sel_hs), .hs_stop(hs_stop), .ih_stop(ih_stop),
  .hs_on(hs_on), .ih_on(ih_on),
  .wr_en(wr_en), .wr_addr(wr_addr), .freq(freq)
);

// File: tb/tb_clk_src_ctrl.sv
`timescale 1ns/1ps
module tb_clk_src_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [3:0] cfg_freq = 4'd2;
  logic [1:0] cfg_mode = 2'd0;
  logic       stop_req = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       hs_clk = 0, ih_clk = 0, hs_valid = 0, ih_valid = 0;
  logic       hs_osc_en, ih_osc_en, main_clk, src_hs;
  logic [3:0] ih_freq;

  int checks = 0, failures = 0;
  int edges = 0, short_pulses = 0;
  realtime rise_t = 0;

  always #5 clk = ~clk;
  always #4 ih_clk = ~ih_clk;
  always #7 hs_clk = ~hs_clk;
  always @(posedge ih_clk) ih_valid <= ih_osc_en;
  always @(posedge hs_clk) hs_valid <= hs_osc_en;

  always @(posedge main_clk) begin edges++; rise_t = $realtime; end
  always @(negedge main_clk) if ($realtime - rise_t < 3.9) short_pulses++;

  clk_src_ctrl dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic count_edges(input int ns, output int n);
    int n0;
    n0 = edges; #(ns); n = edges - n0;
  endtask

  task automatic t_reset;
    int v, n;
    rd(2'd0, v); chk("R1 stop reg", v, 'h80);
    rd(2'd1, v); chk("R1 sel reg", v, 'h00);
    rd(2'd2, v); chk("R1 freq reg", v, 2);
    chk("R1 ih_freq", ih_freq, 2);
    chk("R3 hs_osc_en at reset", hs_osc_en, 0);
    chk("R3 ih_osc_en at reset", ih_osc_en, 1);
    repeat (20) @(negedge clk);
    chk("R1 src_hs", src_hs, 0);
    count_edges(400, n); chk_near("R1 on-chip edge rate", n, 50);
  endtask

  task automatic t_freq;
    int v;
    wr(2'd2, 8'h05); rd(2'd2, v); chk("R2 valid code", v, 5);
    wr(2'd2, 8'h0C); rd(2'd2, v); chk("R2 undefined code", v, 5);
    cfg_mode = 2'd2;
    wr(2'd2, 8'h03); rd(2'd2, v); chk("R2 low-voltage limit", v, 5);
    wr(2'd2, 8'h07); rd(2'd2, v); chk("R2 low-voltage ok", v, 7);
    cfg_mode = 2'd1;
    wr(2'd2, 8'h00); rd(2'd2, v); chk("R2 low-speed limit", v, 7);
    wr(2'd2, 8'h01); rd(2'd2, v); chk("R2 low-speed ok", v, 1);
    chk("R2 ih_freq follows", ih_freq, 1);
    cfg_mode = 2'd0;
  endtask

  task automatic t_stop_bits;
    int v;
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R3 clear hs stop", v, 'h00);
    chk("R3 hs_osc_en", hs_osc_en, 1);
    wr(2'd0, 8'h01); rd(2'd0, v); chk("R6 selected ih stop ignored", v, 'h00);
    chk("R6 ih_osc_en kept", ih_osc_en, 1);
  endtask

  task automatic t_switch;
    int v, n;
    wr(2'd1, 8'h10);
    repeat (40) @(negedge clk);
    chk("R7 src_hs after switch", src_hs, 1);
    rd(2'd1, v); chk("R7 status bit", v, 'h30);
    count_edges(700, n); chk_near("R5 hs edge rate", n, 50);
    wr(2'd0, 8'h80); rd(2'd0, v); chk("R6 selected hs stop ignored", v, 'h00);
    wr(2'd0, 8'h01); rd(2'd0, v); chk("R3 idle ih stop", v, 'h01);
    chk("R3 ih_osc_en off", ih_osc_en, 0);
    wr(2'd1, 8'h00); rd(2'd1, v); chk("R5 select of stopped source", v, 'h30);
  endtask

  task automatic t_stop_mode;
    int n;
    @(negedge clk); stop_req = 1; #1;
    chk("R4 hs enable in stop", hs_osc_en, 0);
    chk("R4 ih enable in stop", ih_osc_en, 0);
    repeat (10) @(negedge clk);
    count_edges(200, n); chk("R8 gated in stop", n, 0);
    @(negedge clk); stop_req = 0; #1;
    chk("R4 hs re-enabled", hs_osc_en, 1);
    chk("R4 stopped ih stays off", ih_osc_en, 0);
    repeat (30) @(negedge clk);
    count_edges(700, n); chk_near("R8 resumes on hs", n, 50);
  endtask

  task automatic t_switch_back;
    int n;
    wr(2'd0, 8'h00);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h00);
    repeat (40) @(negedge clk);
    chk("R7 src back to on-chip", src_hs, 0);
    count_edges(400, n); chk_near("R7 on-chip edge rate", n, 50);
    chk("R7 no short pulses", short_pulses, 0);
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_freq();
    t_stop_bits();
    t_switch();
    t_stop_mode();
    t_switch_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule